// File: doc/BRIEF.md
# Test-Access-Port Controller State Machine

This block is the sequencing core of a boundary-scan test port. A sixteen-state machine advances on every rising edge of the test clock, with the single mode-select input as its only steering. A data-register path and an instruction-register path are built from the same seven-step sequence: select, capture, shift, exit, pause, second exit and update. A common test-logic-reset state and a common idle state join the two paths.

From the current state the block derives the control signals that the instruction register and the data registers use. Some are registered on the falling test-clock edge so that they are stable across the next rising edge: the serial-output enable, the two shift selects and an internal active-low reset. The others are combinational enables. The capture/shift enables are meant to be sampled on the rising edge. The update enables are meant to be sampled on the falling edge. No gated or derived clock is created. The instruction decoder, the register chains and the pad logic sit outside the block.

Top module: `tap_fsm_ctrl`

## Requirements
- R1: When `trst_n` is low at a rising edge of `tck`, `state_o` is 0 (test-logic-reset) after that edge. At the next falling edge `rst_o_n`, `tdo_en_o`, `shift_ir_o` and `shift_dr_o` are all 0.
- R2: `state_o` encodes the states as 0 reset, 1 idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR. Reset holds when `tms`=1. Idle, both shift states and both pause states hold when `tms`=0.
- R3: Data-path transitions (`tms`=0 / `tms`=1): reset→idle/reset; idle→idle/select-DR; select-DR→capture-DR/select-IR; capture-DR→shift-DR/exit1-DR; exit1-DR→pause-DR/update-DR; pause-DR→pause-DR/exit2-DR; exit2-DR→shift-DR/update-DR; update-DR→idle/select-DR.
- R4: The instruction path follows the same pattern as the data path, with select-IR→capture-IR on `tms`=0 and select-IR→reset on `tms`=1.
- R5: Five consecutive rising edges with `tms`=1 bring the machine to reset from any state.
- R6: `tdo_en_o` is 1 exactly while the state is shift-DR or shift-IR. `shift_dr_o` is 1 only in shift-DR and `shift_ir_o` only in shift-IR. All three are registered on the falling edge of `tck`.
- R7: `rst_o_n` is 0 exactly while the state is reset. It is registered on the falling edge.
- R8: `sel_ir_o` is 1 in reset, idle and states 9 to 15, and 0 in states 2 to 8.
- R9: `clk_ir_en_o` is 1 exactly in capture-IR or shift-IR. `clk_dr_en_o` is 1 exactly in capture-DR or shift-DR.
- R10: `upd_ir_en_o` is 1 only in update-IR and `upd_dr_en_o` only in update-DR. Both are single-state enables for a falling-edge update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; state advances on its rising edge |
| trst_n | input | 1 | Active-low test reset, sampled on both edges |
| tms | input | 1 | Mode select steering every transition |
| state_o | output | 4 | Current state code |
| rst_o_n | output | 1 | Active-low reset for the test registers (falling-edge registered) |
| sel_ir_o | output | 1 | Selects the instruction path for serial output |
| tdo_en_o | output | 1 | Serial output enable (falling-edge registered) |
| shift_ir_o | output | 1 | Instruction register shift select (falling-edge registered) |
| shift_dr_o | output | 1 | Data register shift select (falling-edge registered) |
| clk_ir_en_o | output | 1 | Instruction register capture/shift enable |
| clk_dr_en_o | output | 1 | Data register capture/shift enable |
| upd_ir_en_o | output | 1 | Instruction register update enable |
| upd_dr_en_o | output | 1 | Data register update enable |

## Verification
The bench drives the machine into each of the sixteen states. From each one it applies both values of `tms`, so every one of the 32 transitions is checked. A mix-up between the data and instruction columns, or a wrong exit2/update target, shows up as a wrong state code. From every state it also applies five ones and expects reset. A machine that sends select-IR anywhere other than reset, or that loops among the exit states, fails this sweep. A long pseudo-random walk checks every output in every cycle. This catches enables that are tied to the wrong phase or decoded from the neighbouring state.

// File: rtl/tap_fsm_pkg.sv
// Shared state encoding for the test-access-port controller.
// Assumes a 4-bit code; the data path uses codes 2..8, instruction path 9..15.
package tap_fsm_pkg;
    localparam int STATE_W   = 4;
    localparam int ONES_TO_RESET = 5;
    localparam int ONES_W    = $clog2(ONES_TO_RESET + 1);

    typedef enum logic [STATE_W-1:0] {
        ST_RESET  = 4'd0,
        ST_IDLE   = 4'd1,
        ST_SEL_DR = 4'd2,
        ST_CAP_DR = 4'd3,
        ST_SH_DR  = 4'd4,
        ST_EX1_DR = 4'd5,
        ST_PA_DR  = 4'd6,
        ST_EX2_DR = 4'd7,
        ST_UPD_DR = 4'd8,
        ST_SEL_IR = 4'd9,
        ST_CAP_IR = 4'd10,
        ST_SH_IR  = 4'd11,
        ST_EX1_IR = 4'd12,
        ST_PA_IR  = 4'd13,
        ST_EX2_IR = 4'd14,
        ST_UPD_IR = 4'd15
    } tap_state_t;
endpackage

// File: rtl/tap_fsm_next.sv
// Next-state function of the controller. Purely combinational.
// Assumes the caller registers the result on the rising test-clock edge.
module tap_fsm_next
    import tap_fsm_pkg::*;
(
    input  tap_state_t cur_i,
    input  logic       tms_i,
    output tap_state_t nxt_o
);
    // Transition table: one case per state, tms selects the branch.
    always_comb begin
        nxt_o = ST_RESET;
        unique case (cur_i)
            ST_RESET:  nxt_o = tms_i ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt_o = tms_i ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt_o = tms_i ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt_o = tms_i ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt_o = tms_i ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt_o = tms_i ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  nxt_o = tms_i ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: nxt_o = tms_i ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt_o = tms_i ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt_o = tms_i ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt_o = tms_i ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt_o = tms_i ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt_o = tms_i ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  nxt_o = tms_i ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: nxt_o = tms_i ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt_o = tms_i ? ST_SEL_IR : ST_IDLE;
            default:   nxt_o = ST_RESET;
        endcase
    end
endmodule

// File: rtl/tap_fsm_outs.sv
// Output decode of the controller.
// Registers the serial-output enable, shift selects and internal reset on the
// falling test-clock edge. Capture/shift and update enables are combinational
// from the state, for rising- and falling-edge sampling respectively.
// Assumes trst_n is synchronous to tck.
module tap_fsm_outs
    import tap_fsm_pkg::*;
#(
    parameter int NEG_N = 4
)(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_t st_i,
    output logic       rst_n_o,
    output logic       tdo_en_o,
    output logic       shift_ir_o,
    output logic       shift_dr_o,
    output logic       sel_ir_o,
    output logic       clk_ir_en_o,
    output logic       clk_dr_en_o,
    output logic       upd_ir_en_o,
    output logic       upd_dr_en_o
);
    logic [NEG_N-1:0] neg_d;
    logic [NEG_N-1:0] neg_q;

    // Decode of the falling-edge registered group: {rst_n, tdo_en, sh_ir, sh_dr}.
    always_comb begin
        neg_d = '0;
        neg_d[3] = (st_i != ST_RESET);
        neg_d[2] = (st_i == ST_SH_IR) || (st_i == ST_SH_DR);
        neg_d[1] = (st_i == ST_SH_IR);
        neg_d[0] = (st_i == ST_SH_DR);
    end

    // One falling-edge flop per registered output, cleared during reset.
    for (genvar g = 0; g < NEG_N; g++) begin : g_neg
        always_ff @(negedge tck) begin
            if (!trst_n) neg_q[g] <= 1'b0;
            else         neg_q[g] <= neg_d[g];
        end
    end

    assign rst_n_o    = neg_q[3];
    assign tdo_en_o   = neg_q[2];
    assign shift_ir_o = neg_q[1];
    assign shift_dr_o = neg_q[0];

    // Path select and the clock-enable strobes decoded straight from the state.
    always_comb begin
        sel_ir_o    = (st_i == ST_RESET) || (st_i == ST_IDLE) || (st_i >= ST_SEL_IR);
        clk_ir_en_o = (st_i == ST_CAP_IR) || (st_i == ST_SH_IR);
        clk_dr_en_o = (st_i == ST_CAP_DR) || (st_i == ST_SH_DR);
        upd_ir_en_o = (st_i == ST_UPD_IR);
        upd_dr_en_o = (st_i == ST_UPD_DR);
    end

    // R6: shift-state selects and output enable are in place by the next rising edge.
    p_shift_dr_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (st_i == ST_SH_DR) |-> (shift_dr_o && tdo_en_o && !shift_ir_o));
    p_shift_ir_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (st_i == ST_SH_IR) |-> (shift_ir_o && tdo_en_o && !shift_dr_o));
    // R7: internal reset is asserted while the machine sits in reset.
    p_rst_low_r7: assert property (@(posedge tck) disable iff (!trst_n)
        (st_i == ST_RESET) |-> !rst_n_o);
endmodule

// File: rtl/tap_fsm_ctrl.sv
// Top of the test-access-port controller: state register plus next-state and
// output decode. Single tck domain, synchronous active-low reset, no gated clocks.
module tap_fsm_ctrl
    import tap_fsm_pkg::*;
(
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    output logic [STATE_W-1:0] state_o,
    output logic               rst_o_n,
    output logic               sel_ir_o,
    output logic               tdo_en_o,
    output logic               shift_ir_o,
    output logic               shift_dr_o,
    output logic               clk_ir_en_o,
    output logic               clk_dr_en_o,
    output logic               upd_ir_en_o,
    output logic               upd_dr_en_o
);
    tap_state_t st_q;
    tap_state_t st_d;

    tap_fsm_next u_next (
        .cur_i (st_q),
        .tms_i (tms),
        .nxt_o (st_d)
    );

    // State register, advanced on the rising edge.
    always_ff @(posedge tck) begin
        if (!trst_n) st_q <= ST_RESET;
        else         st_q <= st_d;
    end

    tap_fsm_outs #(.NEG_N(4)) u_outs (
        .tck         (tck),
        .trst_n      (trst_n),
        .st_i        (st_q),
        .rst_n_o     (rst_o_n),
        .tdo_en_o    (tdo_en_o),
        .shift_ir_o  (shift_ir_o),
        .shift_dr_o  (shift_dr_o),
        .sel_ir_o    (sel_ir_o),
        .clk_ir_en_o (clk_ir_en_o),
        .clk_dr_en_o (clk_dr_en_o),
        .upd_ir_en_o (upd_ir_en_o),
        .upd_dr_en_o (upd_dr_en_o)
    );

    assign state_o = st_q;

    // Checker counter: consecutive tms=1 edges, saturating at the reset limit.
    logic [ONES_W-1:0] ones_q;
    always_ff @(posedge tck) begin
        if (!trst_n)                                    ones_q <= '0;
        else if (!tms)                                  ones_q <= '0;
        else if (ones_q != ONES_W'(ONES_TO_RESET))      ones_q <= ones_q + 1'b1;
    end

    // R1: reset forces the reset state.
    p_trst_r1: assert property (@(posedge tck)
        (trst_n === 1'b0) |=> (st_q == ST_RESET));
    // R2: reset is held while tms stays high.
    p_hold_reset_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (st_q == ST_RESET && tms) |=> (st_q == ST_RESET));
    // R3: update-DR with tms low returns to idle.
    p_upd_idle_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (st_q == ST_UPD_DR && !tms) |=> (st_q == ST_IDLE));
    // R4: select-IR with tms high escapes to reset.
    p_selir_escape_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (st_q == ST_SEL_IR && tms) |=> (st_q == ST_RESET));
    // R5: after the reset limit of consecutive ones the machine is in reset.
    p_ones_reach_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q == ONES_W'(ONES_TO_RESET)) |-> (st_q == ST_RESET));
endmodule

// File: tb/tap_fsm_ctrl_tb_top.sv
// Exhaustive transition sweep plus a pseudo-random walk with per-cycle output checks.
module tap_fsm_ctrl_tb_top;
    localparam int TCK_PERIOD = 10;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic [3:0] state_o;
    logic rst_o_n, sel_ir_o, tdo_en_o, shift_ir_o, shift_dr_o;
    logic clk_ir_en_o, clk_dr_en_o, upd_ir_en_o, upd_dr_en_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] model = 4'd0;

    always #(TCK_PERIOD/2) tck = ~tck;

    tap_fsm_ctrl dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state_o(state_o),
        .rst_o_n(rst_o_n), .sel_ir_o(sel_ir_o), .tdo_en_o(tdo_en_o),
        .shift_ir_o(shift_ir_o), .shift_dr_o(shift_dr_o),
        .clk_ir_en_o(clk_ir_en_o), .clk_dr_en_o(clk_dr_en_o),
        .upd_ir_en_o(upd_ir_en_o), .upd_dr_en_o(upd_dr_en_o)
    );

    // Expected next state, written from the R2..R4 transition lists.
    function automatic logic [3:0] ref_next(input logic [3:0] s, input logic t);
        case (s)
            4'd0:  return t ? 4'd0 : 4'd1;
            4'd1:  return t ? 4'd2 : 4'd1;
            4'd2:  return t ? 4'd9 : 4'd3;
            4'd9:  return t ? 4'd0 : 4'd10;
            4'd3, 4'd4:   return t ? 4'd5 : 4'd4;
            4'd10, 4'd11: return t ? 4'd12 : 4'd11;
            4'd5:  return t ? 4'd8 : 4'd6;
            4'd12: return t ? 4'd15 : 4'd13;
            4'd6:  return t ? 4'd7 : 4'd6;
            4'd13: return t ? 4'd14 : 4'd13;
            4'd7:  return t ? 4'd8 : 4'd4;
            4'd14: return t ? 4'd15 : 4'd11;
            4'd8:  return t ? 4'd2 : 4'd1;
            default: return t ? 4'd9 : 4'd1;
        endcase
    endfunction

    // TMS path from reset to each state: {length, bits applied LSB first}.
    function automatic logic [11:0] path_to(input logic [3:0] s);
        case (s)
            4'd1:  return {4'd1, 8'b0000_0000};
            4'd2:  return {4'd2, 8'b0000_0010};
            4'd3:  return {4'd3, 8'b0000_0010};
            4'd4:  return {4'd4, 8'b0000_0010};
            4'd5:  return {4'd4, 8'b0000_1010};
            4'd6:  return {4'd5, 8'b0000_1010};
            4'd7:  return {4'd6, 8'b0010_1010};
            4'd8:  return {4'd5, 8'b0001_1010};
            4'd9:  return {4'd3, 8'b0000_0110};
            4'd10: return {4'd4, 8'b0000_0110};
            4'd11: return {4'd5, 8'b0000_0110};
            4'd12: return {4'd5, 8'b0001_0110};
            4'd13: return {4'd6, 8'b0001_0110};
            4'd14: return {4'd7, 8'b0101_0110};
            4'd15: return {4'd6, 8'b0011_0110};
            default: return 12'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (model state %0d)", req, act, exp, model);
        end
    endtask

    // Combinational enables, checked after the rising edge.
    task automatic chk_comb();
        chk("R8 sel_ir", {3'd0, sel_ir_o}, {3'd0, (model <= 4'd1) || (model >= 4'd9)});
        chk("R9 clk_ir_en", {3'd0, clk_ir_en_o}, {3'd0, (model == 4'd10) || (model == 4'd11)});
        chk("R9 clk_dr_en", {3'd0, clk_dr_en_o}, {3'd0, (model == 4'd3) || (model == 4'd4)});
        chk("R10 upd_ir_en", {3'd0, upd_ir_en_o}, {3'd0, model == 4'd15});
        chk("R10 upd_dr_en", {3'd0, upd_dr_en_o}, {3'd0, model == 4'd8});
    endtask

    // Falling-edge registered outputs, checked after the falling edge.
    task automatic chk_neg();
        chk("R7 rst_o_n", {3'd0, rst_o_n}, {3'd0, model != 4'd0});
        chk("R6 tdo_en", {3'd0, tdo_en_o}, {3'd0, (model == 4'd4) || (model == 4'd11)});
        chk("R6 shift_ir", {3'd0, shift_ir_o}, {3'd0, model == 4'd11});
        chk("R6 shift_dr", {3'd0, shift_dr_o}, {3'd0, model == 4'd4});
    endtask

    // One tck cycle with the given tms; starts and ends just after a falling edge.
    task automatic step(input logic t, input string req);
        tms = t;
        @(posedge tck); #1;
        model = ref_next(model, t);
        chk(req, state_o, model);
        chk_comb();
        @(negedge tck); #1;
        chk_neg();
    endtask

    task automatic do_reset();
        trst_n = 1'b0;
        tms = 1'b0;
        @(posedge tck); #1;
        model = 4'd0;
        chk("R1 state after trst", state_o, 4'd0);
        @(negedge tck); #1;
        chk("R1 rst_o_n low", {3'd0, rst_o_n}, 4'd0);
        chk("R1 shift/tdo clear", {1'b0, tdo_en_o, shift_ir_o, shift_dr_o}, 4'd0);
        trst_n = 1'b1;
    endtask

    task automatic go_to(input logic [3:0] s);
        logic [11:0] p;
        p = path_to(s);
        do_reset();
        for (int i = 0; i < int'(p[11:8]); i++) step(p[i], "R3 path");
        chk("R2 reached", state_o, s);
    endtask

    initial begin
        #(TCK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge tck); #1;
        do_reset();
        // R2: reset holds on tms=1 across several edges.
        for (int i = 0; i < 3; i++) step(1'b1, "R2 reset hold");
        // Every state, both tms values (R3 data column, R4 instruction column).
        for (int s = 0; s < 16; s++) begin
            go_to(4'(s));
            step(1'b0, s >= 9 ? "R4 tms0" : "R3 tms0");
            go_to(4'(s));
            step(1'b1, s >= 9 ? "R4 tms1" : "R3 tms1");
        end
        // R5: five ones from every state reach reset.
        for (int s = 0; s < 16; s++) begin
            go_to(4'(s));
            for (int k = 0; k < 5; k++) step(1'b1, "R5 walk");
            chk("R5 five ones", state_o, 4'd0);
        end
        // Long pseudo-random walk with all outputs checked each cycle.
        do_reset();
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] & (lfsr[3] | lfsr[7]), "R2 random walk");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule